// File: doc/BRIEF.md
# Configurable Product-Term Sum Cell

This block models the combinational heart of one cell of a programmable logic array. A vector of global signals and a vector of regional signals feed five product terms. Each term is an AND over every input, and each input can be taken true, taken inverted, or ignored. A static configuration decides which terms are ORed into the cell's sum and which are handed out unchanged as control terms. Those control terms serve as register data, clock, enable, reset, preset or output enable in the surrounding cell.

The sum also takes in a cascade input from a neighbouring cell. The complete sum leaves on the cascade output, so cells can be chained by direct wiring: eight cells of five terms give a sum of forty terms. Selected regional lines can be ORed straight into the sum. Because each cell of a region drives an inverted term onto the regional lines, one cell can gather its own five terms plus sixteen regional terms. An XOR stage combines the sum with a constant 0, a constant 1 (polarity inversion) or one chosen product term. The cell drives the inverse of one chosen term as its foldback output. All configuration is static and the block has no state.

Top module: `pterm_macrocell`

## Requirements
- R1: Input index j selects glb_in[j] for j < N_GLB and rgn_in[j-N_GLB] above that. For term t, the literal code of input j sits in cfg_lit[(t*N_IN+j)*2 +: 2]. Bit 0 set means the input must be 1, bit 1 set means the input must be 0, code 00 means don't-care, and code 11 forces the term to 0. A term whose codes are all 00 evaluates to 1.
- R2: Each term t whose cfg_to_sum[t] is 1 is ORed into the sum. Any number of the five terms, from none to all, may be routed.
- R3: casc_in is ORed into the sum, and casc_out carries the complete sum, so that casc_out of one cell can drive casc_in of the next.
- R4: xor_out is the sum XOR a second operand chosen by cfg_xor_mode: 0 gives constant 0, 1 gives constant 1 (inverted output), 2 gives product term cfg_xor_pt, and 3 behaves as 0.
- R5: ctrl_pt[t] equals term t when cfg_to_sum[t] is 0, and is 0 when the term is routed into the sum.
- R6: fold_out is the inverse of product term cfg_fold_pt. When that index is 5 or more, fold_out is 1.
- R7: Each regional line r with cfg_rgn_or[r] set is ORed directly into the sum. A line with its enable clear has no direct effect on the sum.
- R8: In mode 2, a cfg_xor_pt index of 5 or more selects a 0 operand, so xor_out equals the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| glb_in | input | N_GLB | Global bus signals |
| rgn_in | input | N_RGN | Regional bus signals, including foldback lines |
| casc_in | input | 1 | Sum arriving from the neighbouring cell |
| cfg_lit | input | NUM_PT*N_IN*2 | Literal codes of all product terms |
| cfg_to_sum | input | NUM_PT | Per-term routing into the sum |
| cfg_rgn_or | input | N_RGN | Per-line direct OR of regional lines into the sum |
| cfg_xor_mode | input | 2 | Second XOR operand select |
| cfg_xor_pt | input | IDX_W | Term index used by XOR mode 2 |
| cfg_fold_pt | input | IDX_W | Term index inverted onto the foldback output |
| xor_out | output | 1 | Sum after the XOR stage |
| casc_out | output | 1 | Complete sum for the next cell |
| ctrl_pt | output | NUM_PT | Terms not routed into the sum |
| fold_out | output | 1 | Inverted selected term for the regional bus |

## Verification
A single product term can feed three functions at once: it can be routed into the sum, be the XOR's second operand, and be the foldback source, all in the same evaluation. The random phase draws the XOR and foldback indices from the same small range and routes terms at random, so these overlaps are frequent. Every output is compared each cycle with a sum-of-products model built from the literal codes. A dedicated case sets both indices to a term that is also in the sum. In that case xor_out must fall to 0 when the term is 1, while fold_out is also 0.

// File: rtl/pterm_pkg.sv
package pterm_pkg;
  localparam int LIT_W = 2;

  typedef enum logic [1:0] {
    XSEL_ZERO = 2'd0,
    XSEL_ONE  = 2'd1,
    XSEL_TERM = 2'd2,
    XSEL_RSVD = 2'd3
  } xsel_e;
endpackage

// File: rtl/pterm_and.sv
module pterm_and #(
  parameter int N_IN = 40
) (
  input  logic [N_IN-1:0]                   in_vec,
  input  logic [N_IN*pterm_pkg::LIT_W-1:0]  lit,
  output logic                              term
);
  logic [N_IN-1:0] lit_ok;

  // each literal passes unless its required level is absent
  for (genvar j = 0; j < N_IN; j++) begin : g_lit
    logic need_hi;
    logic need_lo;
    assign need_hi   = lit[j*pterm_pkg::LIT_W];
    assign need_lo   = lit[j*pterm_pkg::LIT_W + 1];
    assign lit_ok[j] = ~(need_hi & ~in_vec[j]) & ~(need_lo & in_vec[j]);
  end

  assign term = &lit_ok;
endmodule

// File: rtl/pterm_sum.sv
module pterm_sum #(
  parameter int NUM_PT = 5,
  parameter int N_RGN  = 16
) (
  input  logic [NUM_PT-1:0] pt,
  input  logic [NUM_PT-1:0] to_sum,
  input  logic [N_RGN-1:0]  rgn_in,
  input  logic [N_RGN-1:0]  rgn_or,
  input  logic              casc_in,
  output logic              sum,
  output logic [NUM_PT-1:0] ctrl
);
  logic [NUM_PT-1:0] routed;
  logic [N_RGN-1:0]  rgn_hit;

  for (genvar t = 0; t < NUM_PT; t++) begin : g_steer
    assign routed[t] = pt[t] & to_sum[t];
    assign ctrl[t]   = pt[t] & ~to_sum[t];
  end

  assign rgn_hit = rgn_in & rgn_or;
  assign sum     = (|routed) | (|rgn_hit) | casc_in;
endmodule

// File: rtl/pterm_xor_fold.sv
module pterm_xor_fold #(
  parameter int NUM_PT = 5,
  parameter int IDX_W  = 3
) (
  input  logic [NUM_PT-1:0] pt,
  input  logic              sum,
  input  logic [1:0]        xor_mode,
  input  logic [IDX_W-1:0]  xor_idx,
  input  logic [IDX_W-1:0]  fold_idx,
  output logic              xor_out,
  output logic              fold_out
);
  import pterm_pkg::*;

  logic  xor_term;
  logic  fold_term;
  logic  operand;
  xsel_e mode;

  // out-of-range indices pick nothing, leaving a 0 term
  always_comb begin
    xor_term  = 1'b0;
    fold_term = 1'b0;
    for (int t = 0; t < NUM_PT; t++) begin
      if (xor_idx == IDX_W'(t))  xor_term  = pt[t];
      if (fold_idx == IDX_W'(t)) fold_term = pt[t];
    end
  end

  assign mode = xsel_e'(xor_mode);

  always_comb begin
    case (mode)
      XSEL_ONE:  operand = 1'b1;
      XSEL_TERM: operand = xor_term;
      default:   operand = 1'b0;
    endcase
  end

  assign xor_out  = sum ^ operand;
  assign fold_out = ~fold_term;
endmodule

// File: rtl/pterm_macrocell.sv
module pterm_macrocell #(
  parameter int N_GLB  = 24,
  parameter int N_RGN  = 16,
  parameter int NUM_PT = 5,
  parameter int N_IN   = N_GLB + N_RGN,
  parameter int IDX_W  = $clog2(NUM_PT + 1)
) (
  input  logic [N_GLB-1:0]                         glb_in,
  input  logic [N_RGN-1:0]                         rgn_in,
  input  logic                                     casc_in,
  input  logic [NUM_PT*N_IN*pterm_pkg::LIT_W-1:0]  cfg_lit,
  input  logic [NUM_PT-1:0]                        cfg_to_sum,
  input  logic [N_RGN-1:0]                         cfg_rgn_or,
  input  logic [1:0]                               cfg_xor_mode,
  input  logic [IDX_W-1:0]                         cfg_xor_pt,
  input  logic [IDX_W-1:0]                         cfg_fold_pt,
  output logic                                     xor_out,
  output logic                                     casc_out,
  output logic [NUM_PT-1:0]                        ctrl_pt,
  output logic                                     fold_out
);
  localparam int TERM_CFG_W = N_IN * pterm_pkg::LIT_W;

  logic [N_IN-1:0]   in_vec;
  logic [NUM_PT-1:0] pt;
  logic              sum;

  assign in_vec = {rgn_in, glb_in};

  for (genvar t = 0; t < NUM_PT; t++) begin : g_term
    pterm_and #(.N_IN(N_IN)) i_and (
      .in_vec (in_vec),
      .lit    (cfg_lit[t*TERM_CFG_W +: TERM_CFG_W]),
      .term   (pt[t])
    );
  end

  pterm_sum #(.NUM_PT(NUM_PT), .N_RGN(N_RGN)) i_sum (
    .pt      (pt),
    .to_sum  (cfg_to_sum),
    .rgn_in  (rgn_in),
    .rgn_or  (cfg_rgn_or),
    .casc_in (casc_in),
    .sum     (sum),
    .ctrl    (ctrl_pt)
  );

  pterm_xor_fold #(.NUM_PT(NUM_PT), .IDX_W(IDX_W)) i_xf (
    .pt       (pt),
    .sum      (sum),
    .xor_mode (cfg_xor_mode),
    .xor_idx  (cfg_xor_pt),
    .fold_idx (cfg_fold_pt),
    .xor_out  (xor_out),
    .fold_out (fold_out)
  );

  assign casc_out = sum;
endmodule

// File: rtl/pterm_macrocell_chk.sv
module pterm_macrocell_chk #(
  parameter int N_GLB  = 24,
  parameter int N_RGN  = 16,
  parameter int NUM_PT = 5,
  parameter int N_IN   = N_GLB + N_RGN,
  parameter int IDX_W  = $clog2(NUM_PT + 1)
) (
  input logic [N_GLB-1:0]                         glb_in,
  input logic [N_RGN-1:0]                         rgn_in,
  input logic                                     casc_in,
  input logic [NUM_PT*N_IN*pterm_pkg::LIT_W-1:0]  cfg_lit,
  input logic [NUM_PT-1:0]                        cfg_to_sum,
  input logic [N_RGN-1:0]                         cfg_rgn_or,
  input logic [1:0]                               cfg_xor_mode,
  input logic [IDX_W-1:0]                         cfg_xor_pt,
  input logic [IDX_W-1:0]                         cfg_fold_pt,
  input logic                                     xor_out,
  input logic                                     casc_out,
  input logic [NUM_PT-1:0]                        ctrl_pt,
  input logic                                     fold_out
);
  always_comb begin
    assert_casc_carry_R3: assert (!casc_in || casc_out)
      else $error("cascade input not reflected in cascade output");
    assert_ctrl_excl_R5: assert ((ctrl_pt & cfg_to_sum) == '0)
      else $error("routed term also appears as control term");
    assert_rgn_or_R7: assert (((rgn_in & cfg_rgn_or) == '0) || casc_out)
      else $error("enabled regional line missing from sum");
    if (cfg_xor_mode == 2'd0 || cfg_xor_mode == 2'd3) begin
      assert_xor_plain_R4: assert (xor_out == casc_out)
        else $error("constant-0 XOR changed the sum");
    end
    if (cfg_xor_mode == 2'd1) begin
      assert_xor_invert_R4: assert (xor_out == !casc_out)
        else $error("constant-1 XOR did not invert the sum");
    end
    if (cfg_xor_mode == 2'd2 && cfg_xor_pt >= IDX_W'(NUM_PT)) begin
      assert_xor_range_R8: assert (xor_out == casc_out)
        else $error("out-of-range XOR term not treated as 0");
    end
    if (cfg_fold_pt >= IDX_W'(NUM_PT)) begin
      assert_fold_range_R6: assert (fold_out)
        else $error("out-of-range foldback index not 1");
    end
  end
endmodule

bind pterm_macrocell pterm_macrocell_chk #(
  .N_GLB(N_GLB), .N_RGN(N_RGN), .NUM_PT(NUM_PT), .N_IN(N_IN), .IDX_W(IDX_W)
) i_chk (.*);

// File: tb/test_pterm_macrocell.sv
module test_pterm_macrocell;
  localparam int CLK_PERIOD = 10;
  localparam int N_GLB  = 24;
  localparam int N_RGN  = 16;
  localparam int NUM_PT = 5;
  localparam int N_IN   = N_GLB + N_RGN;
  localparam int IDX_W  = 3;
  localparam int LIT_BITS = NUM_PT * N_IN * 2;

  logic clk;
  logic [N_GLB-1:0]    glb_in;
  logic [N_RGN-1:0]    rgn_in;
  logic                casc_in;
  logic [LIT_BITS-1:0] cfg_lit;
  logic [NUM_PT-1:0]   cfg_to_sum;
  logic [N_RGN-1:0]    cfg_rgn_or;
  logic [1:0]          cfg_xor_mode;
  logic [IDX_W-1:0]    cfg_xor_pt;
  logic [IDX_W-1:0]    cfg_fold_pt;
  logic                xor_out;
  logic                casc_out;
  logic [NUM_PT-1:0]   ctrl_pt;
  logic                fold_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  pterm_macrocell i_pterm_macrocell (
    .glb_in(glb_in), .rgn_in(rgn_in), .casc_in(casc_in), .cfg_lit(cfg_lit),
    .cfg_to_sum(cfg_to_sum), .cfg_rgn_or(cfg_rgn_or), .cfg_xor_mode(cfg_xor_mode),
    .cfg_xor_pt(cfg_xor_pt), .cfg_fold_pt(cfg_fold_pt), .xor_out(xor_out),
    .casc_out(casc_out), .ctrl_pt(ctrl_pt), .fold_out(fold_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit in_bit(int j);
    return (j < N_GLB) ? glb_in[j] : rgn_in[j - N_GLB];
  endfunction

  function automatic bit ref_term(int t);
    for (int j = 0; j < N_IN; j++) begin
      if (cfg_lit[(t*N_IN + j)*2] && !in_bit(j))     return 1'b0;
      if (cfg_lit[(t*N_IN + j)*2 + 1] && in_bit(j))  return 1'b0;
    end
    return 1'b1;
  endfunction

  // full behavioural comparison of every output
  task automatic compare_all();
    bit [NUM_PT-1:0] terms;
    bit [NUM_PT-1:0] ctrl_exp;
    bit sum_exp, op, fold_exp;
    int xi, fi;
    sum_exp = casc_in;
    for (int t = 0; t < NUM_PT; t++) begin
      terms[t] = ref_term(t);
      if (cfg_to_sum[t]) begin
        if (terms[t]) sum_exp = 1'b1;
        ctrl_exp[t] = 1'b0;
      end else begin
        ctrl_exp[t] = terms[t];
      end
    end
    for (int r = 0; r < N_RGN; r++)
      if (cfg_rgn_or[r] && rgn_in[r]) sum_exp = 1'b1;
    xi = int'(cfg_xor_pt);
    fi = int'(cfg_fold_pt);
    case (cfg_xor_mode)
      2'd1:    op = 1'b1;
      2'd2:    op = (xi < NUM_PT) ? terms[xi] : 1'b0;
      default: op = 1'b0;
    endcase
    fold_exp = (fi < NUM_PT) ? !terms[fi] : 1'b1;
    chk("R3", "casc_out", 32'(casc_out), 32'(sum_exp));
    chk("R4", "xor_out",  32'(xor_out),  32'(sum_exp ^ op));
    chk("R5", "ctrl_pt",  32'(ctrl_pt),  32'(ctrl_exp));
    chk("R6", "fold_out", 32'(fold_out), 32'(fold_exp));
  endtask

  task automatic set_lit(int t, int j, logic [1:0] code);
    cfg_lit[(t*N_IN + j)*2 +: 2] = code;
  endtask

  task automatic clear_cfg();
    glb_in = '0; rgn_in = '0; casc_in = 1'b0; cfg_lit = '0;
    cfg_to_sum = '0; cfg_rgn_or = '0; cfg_xor_mode = 2'd0;
    cfg_xor_pt = '0; cfg_fold_pt = '0;
  endtask

  task automatic kill_all_terms();
    for (int t = 0; t < NUM_PT; t++) set_lit(t, 0, 2'b11);
  endtask

  initial begin
    clear_cfg();
    @(posedge clk);
    @(negedge clk);
    // all don't-care: every term is 1, nothing routed
    chk("R1", "idle ctrl_pt", 32'(ctrl_pt), 32'h1f);
    chk("R3", "idle casc_out", 32'(casc_out), 32'h0);
    chk("R6", "idle fold_out", 32'(fold_out), 32'h0);
    compare_all();

    @(posedge clk); set_lit(0, 0, 2'b11);
    @(negedge clk);
    chk("R1", "contradiction term", 32'(ctrl_pt[0]), 32'h0);

    @(posedge clk); set_lit(1, 3, 2'b01); glb_in = 24'h000008;
    @(negedge clk);
    chk("R1", "true literal met", 32'(ctrl_pt[1]), 32'h1);
    @(posedge clk); glb_in = '0;
    @(negedge clk);
    chk("R1", "true literal missed", 32'(ctrl_pt[1]), 32'h0);
    @(posedge clk); set_lit(2, N_GLB + 4, 2'b10); rgn_in = 16'h0010;
    @(negedge clk);
    chk("R1", "complement literal on regional", 32'(ctrl_pt[2]), 32'h0);

    @(posedge clk); clear_cfg(); kill_all_terms(); set_lit(2, 0, 2'b00);
    cfg_to_sum = 5'b00100;
    @(negedge clk);
    chk("R2", "routed term sums", 32'(casc_out), 32'h1);
    chk("R5", "routed term not control", 32'(ctrl_pt), 32'h0);
    @(posedge clk); cfg_to_sum = 5'b11011;
    @(negedge clk);
    chk("R2", "unrouted true term ignored", 32'(casc_out), 32'h0);
    chk("R5", "unrouted term on control", 32'(ctrl_pt), 32'h04);

    @(posedge clk); clear_cfg(); kill_all_terms(); cfg_to_sum = '1; casc_in = 1'b1;
    @(negedge clk);
    chk("R3", "cascade alone", 32'(casc_out), 32'h1);

    for (int m = 0; m < 4; m++) begin
      @(posedge clk); clear_cfg(); cfg_to_sum = 5'b00001; cfg_xor_mode = 2'(m);
      cfg_xor_pt = 3'd1;
      @(negedge clk);
      chk("R4", "xor mode", 32'(xor_out), (m == 0 || m == 3) ? 32'h1 : 32'h0);
    end

    // one term feeding sum, XOR and foldback together
    @(posedge clk); clear_cfg(); kill_all_terms(); set_lit(3, 0, 2'b00);
    cfg_to_sum = 5'b01000; cfg_xor_mode = 2'd2; cfg_xor_pt = 3'd3; cfg_fold_pt = 3'd3;
    @(negedge clk);
    chk("R4", "shared term xor", 32'(xor_out), 32'h0);
    chk("R6", "shared term fold", 32'(fold_out), 32'h0);

    @(posedge clk); clear_cfg(); cfg_to_sum = 5'b00001; cfg_xor_mode = 2'd2;
    cfg_xor_pt = 3'd7; cfg_fold_pt = 3'd6;
    @(negedge clk);
    chk("R8", "out-of-range xor index", 32'(xor_out), 32'h1);
    chk("R6", "out-of-range fold index", 32'(fold_out), 32'h1);

    @(posedge clk); clear_cfg(); kill_all_terms(); cfg_rgn_or = 16'h0020; rgn_in = 16'h0020;
    @(negedge clk);
    chk("R7", "regional line in sum", 32'(casc_out), 32'h1);
    @(posedge clk); rgn_in = 16'hffdf;
    @(negedge clk);
    chk("R7", "unenabled lines no effect", 32'(casc_out), 32'h0);

    for (int n = 0; n < 600; n++) begin
      @(posedge clk);
      glb_in = N_GLB'($urandom); rgn_in = N_RGN'($urandom); casc_in = ($urandom % 6) == 0;
      for (int t = 0; t < NUM_PT; t++)
        for (int j = 0; j < N_IN; j++)
          set_lit(t, j, (($urandom % 16) == 0) ? 2'($urandom % 4) : 2'b00);
      cfg_to_sum = NUM_PT'($urandom);
      cfg_rgn_or = (($urandom % 3) == 0) ? N_RGN'(1 << ($urandom % N_RGN)) : '0;
      cfg_xor_mode = 2'($urandom);
      cfg_xor_pt = 3'($urandom % 6);
      cfg_fold_pt = 3'($urandom % 6);
      @(negedge clk);
      compare_all();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule